// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square matrices of unsigned 4-bit values on a 4x4 grid of multiply-accumulate cells. Each cell keeps its own result. A start pulse loads both operand matrices. A sequencer then feeds one column of A and one row of B per cycle for four cycles, with zeros before and after. Delay lines skew the operands so that row i of A enters the west edge i cycles late and column j of B enters the north edge j cycles late. Each cell registers the operands it receives and hands them east (A) and south (B). Cell (i,j) therefore meets every matching pair A[i][k], B[k][j] and adds their product to its accumulator.

Once the last product has landed, a select bit goes into the top row and travels south one row per cycle, in step with the operands. While a cell sees select, its output multiplexer loads the value of its west neighbour instead of adding a product. Each row then shifts its four results out of the east edge, one per cycle, with the rightmost column first. No cell needs a parallel read port.

Top module: `sys_matmul`

## Requirements
- R1: While reset is held, and after it is released, `busy_o`, `done_o`, `res_valid_o` and `res_o` are all zero.
- R2: Take cycle 0 as the cycle that follows the clock edge that accepts `start_i`. During cycle 10+i+m, `res_o[i*10 +: 10]` equals C[i][3-m] for m = 0..3, where C = A·B. A[r][c] sits at `a_i[(r*4+c)*4 +: 4]` and B[r][c] sits at `b_i[(r*4+c)*4 +: 4]`. All values are unsigned.
- R3: `res_valid_o[i]` is high in cycles 10+i through 13+i and low in every other cycle of the run.
- R4: `busy_o` is high in cycles 0 through 16. `done_o` is high only in cycle 16, the cycle in which the last result (row 3, column 0) is on the east edge.
- R5: A `start_i` pulse, or a change of `a_i` or `b_i`, while `busy_o` is high has no effect. The timing and the results of the run in progress stay the same.
- R6: Operands of 15 in every position give 900 in every result, with no wrap in the 10-bit accumulator.
- R7: A start raised in the first cycle with `busy_o` low is accepted, and the new run produces correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Loads both matrices and begins a run when idle |
| a_i | input | 64 | Matrix A, element (r,c) at bits (r*4+c)*4 |
| b_i | input | 64 | Matrix B, element (r,c) at bits (r*4+c)*4 |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Last result is on the east edge |
| res_valid_o | output | 4 | Per row: the east edge holds a result |
| res_o | output | 40 | Per row east-edge result, row i at bits i*10 |

## Verification
Every output is fixed to a cycle offset from the accepting edge. Row i presents C[i][3-m] in cycle 10+i+m, its valid bit covers cycles 10+i to 13+i, and done falls in cycle 16. The bench counts cycles from that edge and samples at each falling clock edge from cycle 0 to cycle 17. In each of those cycles it compares busy, done, all four valid bits and every valid result with a product computed in the bench. The runs are chained with no idle cycle between them, so the first cycle with busy low is also checked as an accepting cycle.

// File: rtl/sys_matmul_pkg.sv
package sys_matmul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/mm_skew.sv
module mm_skew #(
  parameter int LANES = 4,
  parameter int W     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LANES*W-1:0] in_i,
  output logic [LANES*W-1:0] out_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_pass
      assign out_o[W-1:0] = in_i[W-1:0];
    end else begin : g_dly
      logic [W-1:0] dly_q [l];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int k = 0; k < l; k++) dly_q[k] <= '0;
        end else begin
          dly_q[0] <= in_i[l*W +: W];
          for (int k = 1; k < l; k++) dly_q[k] <= dly_q[k-1];
        end
      end
      assign out_o[l*W +: W] = dly_q[l-1];
    end
  end
endmodule

// File: rtl/mm_feed.sv
module mm_feed #(
  parameter int N  = 4,
  parameter int DW = 4,
  localparam int IW = $clog2(N),
  localparam int MW = N*N*DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [MW-1:0]   a_i,
  input  logic [MW-1:0]   b_i,
  input  logic            en_i,
  input  logic [IW-1:0]   idx_i,
  output logic [N*DW-1:0] a_lane_o,
  output logic [N*DW-1:0] b_lane_o
);
  logic [MW-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load_i) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  // lane i of A gets column idx; lane j of B gets row idx
  always_comb begin
    a_lane_o = '0;
    b_lane_o = '0;
    if (en_i) begin
      for (int l = 0; l < N; l++) begin
        a_lane_o[l*DW +: DW] = a_q[(l*N + int'(idx_i))*DW +: DW];
        b_lane_o[l*DW +: DW] = b_q[(int'(idx_i)*N + l)*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import sys_matmul_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = $clog2(N),
  localparam int T_SEL = 3*N - 2,
  localparam int T_END = 5*N - 4,
  localparam int CW = $clog2(T_END + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          clr_o,
  output logic          feed_en_o,
  output logic [IW-1:0] feed_idx_o,
  output logic          sel_o,
  output logic          done_o
);
  localparam logic [CW-1:0] FeedEnd = CW'(N);
  localparam logic [CW-1:0] SelBeg  = CW'(T_SEL);
  localparam logic [CW-1:0] SelEnd  = CW'(T_SEL + N - 1);
  localparam logic [CW-1:0] LastCyc = CW'(T_END);

  run_state_e state_q;
  logic [CW-1:0] cnt_q;

  assign busy_o     = (state_q == ST_RUN);
  assign clr_o      = start_i && !busy_o;
  assign feed_en_o  = busy_o && (cnt_q < FeedEnd);
  assign feed_idx_o = cnt_q[IW-1:0];
  assign sel_o      = busy_o && (cnt_q >= SelBeg) && (cnt_q <= SelEnd);
  assign done_o     = busy_o && (cnt_q == LastCyc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (clr_o) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (done_o) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (busy_o) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  AST_DONE_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R4
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> (busy_o && cnt_q == $past(cnt_q) + CW'(1))); // R5
  AST_SEL_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |-> busy_o); // R3
endmodule

// File: rtl/mm_pe.sv
module mm_pe #(
  parameter int DW = 4,
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sel_i,
  input  logic [AW-1:0] shift_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic          sel_o,
  output logic [AW-1:0] acc_o
);
  logic [DW-1:0]   a_q, b_q;
  logic            sel_q;
  logic [AW-1:0]   acc_q;
  logic [2*DW-1:0] prod;
  logic [AW:0]     sum_w;

  assign prod  = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};
  assign sum_w = {1'b0, acc_q} + {{(AW+1-2*DW){1'b0}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      sel_q <= 1'b0;
      acc_q <= '0;
    end else begin
      a_q   <= a_i;
      b_q   <= b_i;
      sel_q <= sel_i;
      if (clr_i)      acc_q <= '0;
      else if (sel_i) acc_q <= shift_i;
      else            acc_q <= sum_w[AW-1:0];
    end
  end

  assign a_o   = a_q;
  assign b_o   = b_q;
  assign sel_o = sel_q;
  assign acc_o = acc_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !sel_i) |-> !sum_w[AW]); // R6
endmodule

// File: rtl/sys_matmul.sv
module sys_matmul
  import sys_matmul_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 4,
  localparam int AW = 2*DW + $clog2(N),
  localparam int IW = $clog2(N),
  localparam int MW = N*N*DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [MW-1:0] a_i,
  input  logic [MW-1:0] b_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [N-1:0]  res_valid_o,
  output logic [N*AW-1:0] res_o
);
  logic          clr, feed_en, sel_src;
  logic [IW-1:0] feed_idx;
  logic [N*DW-1:0] a_lane, b_lane, a_west, b_north;

  mm_ctrl #(.N(N)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .busy_o, .clr_o(clr), .feed_en_o(feed_en), .feed_idx_o(feed_idx),
    .sel_o(sel_src), .done_o
  );

  mm_feed #(.N(N), .DW(DW)) u_feed (
    .clk_i, .rst_ni, .load_i(clr), .a_i, .b_i,
    .en_i(feed_en), .idx_i(feed_idx),
    .a_lane_o(a_lane), .b_lane_o(b_lane)
  );

  mm_skew #(.LANES(N), .W(DW)) u_skew_a (.clk_i, .rst_ni, .in_i(a_lane), .out_o(a_west));
  mm_skew #(.LANES(N), .W(DW)) u_skew_b (.clk_i, .rst_ni, .in_i(b_lane), .out_o(b_north));

  logic [DW-1:0] a_h   [N][N+1];
  logic [DW-1:0] b_v   [N+1][N];
  logic          sel_v [N+1][N];
  logic [AW-1:0] acc_w [N][N+1];
  logic [N*DW-1:0] a_east, b_south;
  logic [N-1:0]    sel_south;

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign a_h[i][0]   = a_west[i*DW +: DW];
    assign b_v[0][i]   = b_north[i*DW +: DW];
    assign sel_v[0][i] = sel_src;
    assign acc_w[i][0] = '0;
    assign res_o[i*AW +: AW] = acc_w[i][N];
    assign res_valid_o[i]    = sel_v[i][N-1];
    assign a_east[i*DW +: DW]  = a_h[i][N];
    assign b_south[i*DW +: DW] = b_v[N][i];
    assign sel_south[i]        = sel_v[N][i];
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      mm_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk_i, .rst_ni, .clr_i(clr),
        .a_i(a_h[i][j]), .b_i(b_v[i][j]), .sel_i(sel_v[i][j]),
        .shift_i(acc_w[i][j]),
        .a_o(a_h[i][j+1]), .b_o(b_v[i+1][j]), .sel_o(sel_v[i+1][j]),
        .acc_o(acc_w[i][j+1])
      );
    end
  end

  for (genvar i = 0; i + 1 < N; i++) begin : g_vchk
    AST_VALID_SKEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(res_valid_o[i]) |=> $rose(res_valid_o[i+1])); // R3
  end
  AST_EDGE_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (a_east == '0 && b_south == '0)); // R2
  AST_SEL_LEAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_south != '0) |-> $past(res_valid_o[N-1])); // R3
endmodule

// File: tb/sys_matmul_bench.sv
`timescale 1ns/1ps
module sys_matmul_bench;
  localparam int N = 4;
  localparam int DW = 4;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [N*N*DW-1:0] a_i = '0, b_i = '0;
  logic busy_o, done_o;
  logic [N-1:0] res_valid_o;
  logic [N*AW-1:0] res_o;

  int total = 0;
  int bad = 0;
  int ma [N][N];
  int mb [N][N];
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  sys_matmul u_sys_matmul (
    .clk_i(clk), .rst_ni, .start_i, .a_i, .b_i,
    .busy_o, .done_o, .res_valid_o, .res_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd4();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hF);
  endfunction

  task automatic run_mm(input bit poke_mid, input string rtag);
    int c [N][N];
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        c[i][j] = 0;
        for (int k = 0; k < N; k++) c[i][j] += ma[i][k] * mb[k][j];
        a_i[(i*N+j)*DW +: DW] = DW'(ma[i][j]);
        b_i[(i*N+j)*DW +: DW] = DW'(mb[i][j]);
      end
    start_i = 1'b1;
    @(posedge clk);
    for (int t = 0; t <= 17; t++) begin
      @(negedge clk);
      chk(busy_o == (t <= 16), (t == 0) ? "R7" : "R4", int'(busy_o), int'(t <= 16));
      chk(done_o == (t == 16), "R4", int'(done_o), int'(t == 16));
      for (int i = 0; i < N; i++) begin
        bit exp_v = (t >= 10 + i) && (t <= 13 + i);
        chk(res_valid_o[i] == exp_v, "R3", int'(res_valid_o[i]), int'(exp_v));
        if (exp_v) begin
          int col = 3 - (t - 10 - i);
          int act = int'(res_o[i*AW +: AW]);
          chk(act == c[i][col], rtag, act, c[i][col]);
        end
      end
      if (t == 0) start_i = 1'b0;
      if (poke_mid && t == 5) begin
        a_i = ~a_i;
        b_i = ~b_i;
        start_i = 1'b1; // R5 stimulus
      end
      if (poke_mid && t == 6) start_i = 1'b0;
    end
  endtask

  initial begin
    #100000;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1", int'(busy_o), 0);
    chk(done_o == 1'b0, "R1", int'(done_o), 0);
    chk(res_valid_o == '0, "R1", int'(res_valid_o), 0);
    chk(res_o == '0, "R1", int'(res_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && res_valid_o == '0, "R1", int'(busy_o), 0);

    // all zero
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin ma[i][j] = 0; mb[i][j] = 0; end
    run_mm(1'b0, "R2");
    // identity times pseudo-random
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin
      ma[i][j] = (i == j) ? 1 : 0; mb[i][j] = rnd4();
    end
    run_mm(1'b0, "R2");
    // ramp values
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin
      ma[i][j] = i*N + j; mb[i][j] = 15 - (j*N + i);
    end
    run_mm(1'b0, "R2");
    // saturating operands
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin ma[i][j] = 15; mb[i][j] = 15; end
    run_mm(1'b0, "R6");
    // back-to-back pseudo-random runs
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin
        ma[i][j] = rnd4(); mb[i][j] = rnd4();
      end
      run_mm(1'b0, "R7");
    end
    // restart and operand change while busy
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) begin
      ma[i][j] = rnd4(); mb[i][j] = rnd4();
    end
    run_mm(1'b1, "R5");
    @(negedge clk);
    chk(busy_o == 1'b0, "R5", int'(busy_o), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule